// File: doc/BRIEF.md
# Lockable PWM Channel with Selectable Output Polarity

This block is a single-channel pulse-width modulator controlled through four word registers: a live counter, a period, a duty and a control word. When it runs, a counter steps once per clock from zero up to one less than the period and then wraps. The output sits at the duty level while the count is below the duty value. It sits at the opposite level for the rest of the period. When the channel does not run, the output holds an idle level. The idle level has its own polarity bit, separate from the duty-phase polarity.

Period and duty writes land in shadow registers. The duty and idle polarity bits live in the control word. Shadow values are copied into the working set only at a period boundary. While the channel is stopped, every cycle counts as a boundary. A lock bit in the control word suspends these copies. Software can set the lock, rewrite period, duty and polarity, and then clear the lock. All the new values then take effect together at the first boundary after the release, so the output never shows a mixed or cut-short pulse.

Top module: `pwmlk_top`

## Requirements
- R1: After reset, the control register reads 0x018 (both polarities positive, channel stopped, unlocked). The counter, period and duty registers read 0, and the output is high.
- R2: Byte offsets 0x0, 0x4, 0x8 and 0xC select counter, period, duty and control. Period and duty read back the last value written, truncated to the counter width and zero-extended. Control reads back the written value masked with 0x17F, so bit 7 and bits 9 and up read 0. Writes to the counter offset have no effect.
- R3: While running, the counter advances by one each clock and returns to 0 after reaching period−1. With a period of 0 or 1 it stays at 0.
- R4: While running, the output is at the duty level when count < duty and at the opposite level otherwise. A duty value at or above the period gives the duty level for the whole period.
- R5: Control bit 3 sets the duty level (1 = high, 0 = low). Control bit 4 sets the idle level (1 = high, 0 = low).
- R6: The channel runs only when control bit 0 is 1 and bits 2:1 equal 01. Otherwise the counter is held at 0 and the output drives the idle level.
- R7: When unlocked, new period, duty and polarity values written while running take effect only at the next wrap, never in the middle of a period.
- R8: While control bit 6 (lock) is set, the working period, duty and polarities stay unchanged, and newly written values wait.
- R9: After the lock is cleared, the pending period, duty and both polarities take effect together at the next period boundary.
- R10: While stopped and unlocked, written values become the working set one cycle later. Starting the channel counts from 0 using those values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one count per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 2 | Byte offset bits 3:2 selecting the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the addressed register (combinational) |
| pwm_out | output | 1 | Modulated output |

## Verification
The bench builds the block with DATA_W = 32 and CNT_W = 8. With an 8-bit counter, random periods stay short, so thousands of cycles cover many wraps, commits landing at wraps, and locks held across several periods. The truncation of wide write data into shadow registers also becomes visible on readback. Directed cases cover periods of 0 and 1, duty at or above the period, and control words that set the enable bit together with a mode code other than continuous.

// File: rtl/pwmlk_pkg.sv
package pwmlk_pkg;

  // register select (byte offset bits 3:2)
  localparam logic [1:0] SEL_CNT  = 2'd0;
  localparam logic [1:0] SEL_PER  = 2'd1;
  localparam logic [1:0] SEL_DUTY = 2'd2;
  localparam logic [1:0] SEL_CTRL = 2'd3;

  // control word layout
  localparam int CTRL_W  = 9;
  localparam int B_EN    = 0;
  localparam int B_MODE  = 1;   // two bits: 2:1
  localparam int B_DPOL  = 3;
  localparam int B_IPOL  = 4;
  localparam int B_LOCK  = 6;
  localparam logic [CTRL_W-1:0] CTRL_MASK = 9'h17F;
  localparam logic [CTRL_W-1:0] CTRL_RST  = 9'h018;
  localparam logic [1:0]        MODE_CONT = 2'b01;

  typedef struct packed {
    logic dpol;   // level during duty phase
    logic ipol;   // level when stopped
  } pol_t;

  // true when the count is the final one of its period (period 0 acts as 1)
  function automatic logic is_last(input logic [63:0] cnt, input logic [63:0] period);
    return (cnt + 64'd1) >= period;
  endfunction

  // true while the count lies within the duty phase
  function automatic logic in_duty(input logic [63:0] cnt, input logic [63:0] duty);
    return cnt < duty;
  endfunction

  // output level from run state, phase and polarity
  function automatic logic out_level(input logic run, input logic duty_phase, input pol_t pol);
    if (!run) return pol.ipol;
    return duty_phase ? pol.dpol : ~pol.dpol;
  endfunction

endpackage

// File: rtl/pwmlk_regfile.sv
module pwmlk_regfile
  import pwmlk_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  live_cnt,
  output logic [DATA_W-1:0] rdata,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [CNT_W-1:0]  shd_period,
  output logic [CNT_W-1:0]  shd_duty
);

  logic unused_wdata;
  assign unused_wdata = ^wdata;

  logic wr_per, wr_duty, wr_ctrl;
  assign wr_per  = wr_en && (sel == SEL_PER);
  assign wr_duty = wr_en && (sel == SEL_DUTY);
  assign wr_ctrl = wr_en && (sel == SEL_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_period <= '0;
      shd_duty   <= '0;
      ctrl_q     <= CTRL_RST;
    end else begin
      if (wr_per)  shd_period <= wdata[CNT_W-1:0];
      if (wr_duty) shd_duty   <= wdata[CNT_W-1:0];
      if (wr_ctrl) ctrl_q     <= wdata[CTRL_W-1:0] & CTRL_MASK;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_CNT:  rdata = DATA_W'(live_cnt);
      SEL_PER:  rdata = DATA_W'(shd_period);
      SEL_DUTY: rdata = DATA_W'(shd_duty);
      default:  rdata = DATA_W'(ctrl_q);
    endcase
  end

endmodule

// File: rtl/pwmlk_commit.sv
module pwmlk_commit
  import pwmlk_pkg::*;
#(
  parameter int CNT_W = 16
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock,
  input  logic             boundary,
  input  logic [CNT_W-1:0] shd_period,
  input  logic [CNT_W-1:0] shd_duty,
  input  pol_t             shd_pol,
  output logic [CNT_W-1:0] act_period,
  output logic [CNT_W-1:0] act_duty,
  output pol_t             act_pol,
  output logic             commit_evt
);

  assign commit_evt = boundary && !lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_period <= '0;
      act_duty   <= '0;
      act_pol    <= '{dpol: 1'b1, ipol: 1'b1};
    end else if (commit_evt) begin
      act_period <= shd_period;
      act_duty   <= shd_duty;
      act_pol    <= shd_pol;
    end
  end

endmodule

// File: rtl/pwmlk_core.sv
module pwmlk_core
  import pwmlk_pkg::*;
#(
  parameter int CNT_W = 16
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] act_period,
  input  logic [CNT_W-1:0] act_duty,
  input  pol_t             act_pol,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap_evt,
  output logic             pwm_out
);

  logic duty_phase;

  assign wrap_evt   = run && is_last(64'(cnt), 64'(act_period));
  assign duty_phase = in_duty(64'(cnt), 64'(act_duty));
  assign pwm_out    = out_level(run, duty_phase, act_pol);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (wrap_evt) cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/pwmlk_top.sv
module pwmlk_top
  import pwmlk_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [3:2]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pwm_out
);

  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  shd_period, shd_duty;
  logic [CNT_W-1:0]  act_period, act_duty;
  logic [CNT_W-1:0]  cnt;
  pol_t              shd_pol, act_pol;
  logic              run, lock, boundary, wrap_evt, commit_evt;

  assign run      = ctrl_q[B_EN] && (ctrl_q[B_MODE+1:B_MODE] == MODE_CONT);
  assign lock     = ctrl_q[B_LOCK];
  assign shd_pol  = '{dpol: ctrl_q[B_DPOL], ipol: ctrl_q[B_IPOL]};
  assign boundary = !run || wrap_evt;

  pwmlk_regfile #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .sel(bus_addr), .wdata(bus_wdata),
    .live_cnt(cnt), .rdata(bus_rdata), .ctrl_q(ctrl_q),
    .shd_period(shd_period), .shd_duty(shd_duty)
  );

  pwmlk_commit #(.CNT_W(CNT_W)) u_commit (
    .clk(clk), .rst_n(rst_n), .lock(lock), .boundary(boundary),
    .shd_period(shd_period), .shd_duty(shd_duty), .shd_pol(shd_pol),
    .act_period(act_period), .act_duty(act_duty), .act_pol(act_pol),
    .commit_evt(commit_evt)
  );

  pwmlk_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .run(run), .act_period(act_period),
    .act_duty(act_duty), .act_pol(act_pol), .cnt(cnt),
    .wrap_evt(wrap_evt), .pwm_out(pwm_out)
  );

endmodule

// File: rtl/pwmlk_chk.sv
module pwmlk_chk
  import pwmlk_pkg::*;
#(
  parameter int CNT_W = 16
)(
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             lock,
  input logic             wrap_evt,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] act_period,
  input logic [CNT_W-1:0] act_duty,
  input pol_t             act_pol,
  input logic             pwm_out
);

  // R8
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> ($stable(act_period) && $stable(act_duty) && $stable(act_pol)));

  // R7
  no_midperiod_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap_evt) |=> ($stable(act_period) && $stable(act_duty) && $stable(act_pol)));

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt == '0 || cnt < act_period));

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap_evt) |=> (!run || cnt == CNT_W'($past(cnt) + 1'b1)));

  // R3
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (cnt == '0));

  // R6
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (pwm_out == act_pol.ipol));

  // R6
  idle_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));

endmodule

bind pwmlk_top pwmlk_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .lock(lock), .wrap_evt(wrap_evt),
  .cnt(cnt), .act_period(act_period), .act_duty(act_duty),
  .act_pol(act_pol), .pwm_out(pwm_out)
);

// File: tb/pwmlk_top_test.sv
module pwmlk_top_test;

  localparam int DW = 32;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [3:2]    bus_addr = 2'd0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          pwm_out;

  always #10 clk = ~clk;

  pwmlk_top #(.DATA_W(DW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  string tag = "R1";
  bit    done = 0;

  // reference state, kept in the bench's own terms
  logic [8:0]    m_ctrl;
  logic [CW-1:0] m_sp, m_sd, m_ap, m_ad, m_cnt;
  logic          m_dp, m_ip;

  function automatic bit m_running(input logic [8:0] c);
    return c[0] == 1'b1 && c[2] == 1'b0 && c[1] == 1'b1;
  endfunction

  function automatic logic expect_out();
    if (!m_running(m_ctrl)) return m_ip;
    if (int'(m_cnt) < int'(m_ad)) return m_dp;
    return !m_dp;
  endfunction

  function automatic logic [DW-1:0] expect_read(input logic [1:0] a);
    case (a)
      2'd0: return {{(DW-CW){1'b0}}, m_cnt};
      2'd1: return {{(DW-CW){1'b0}}, m_sp};
      2'd2: return {{(DW-CW){1'b0}}, m_sd};
      default: return {{(DW-9){1'b0}}, m_ctrl};
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 9'h018; m_sp = 0; m_sd = 0; m_ap = 0; m_ad = 0; m_cnt = 0;
      m_dp = 1; m_ip = 1;
    end else begin
      bit on, last;
      on   = m_running(m_ctrl);
      last = (int'(m_cnt) + 1 >= int'(m_ap));
      if (!m_ctrl[6] && (!on || last)) begin
        m_ap = m_sp; m_ad = m_sd; m_dp = m_ctrl[3]; m_ip = m_ctrl[4];
      end
      if (!on || last) m_cnt = 0;
      else             m_cnt = m_cnt + 1;
      if (bus_wr) begin
        if (bus_addr == 2'd1) m_sp = bus_wdata[CW-1:0];
        if (bus_addr == 2'd2) m_sd = bus_wdata[CW-1:0];
        if (bus_addr == 2'd3) m_ctrl = bus_wdata[8:0] & 9'h17F;
      end
    end
  end

  task automatic check_bit(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s pwm_out actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_word(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s read actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: check output at the falling edge, then drive the next operation
  task automatic step(input bit wr, input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    check_bit(tag, pwm_out, expect_out());
    bus_wr = wr; bus_addr = a; bus_wdata = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 2'd0, '0);
  endtask

  task automatic rd(input string req, input logic [1:0] a);
    step(0, a, '0);
    #1;
    check_word(req, bus_rdata, expect_read(a));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    tag = "R1";
    check_bit("R1", pwm_out, 1'b1);
    for (int a = 0; a < 4; a++) rd("R1", 2'(a));

    // R2 readback, truncation, masking, counter write ignored
    tag = "R2";
    step(1, 2'd1, 32'h1234_56AB); rd("R2", 2'd1);
    step(1, 2'd2, 32'hFFFF_FF3C); rd("R2", 2'd2);
    step(1, 2'd3, 32'hFFFF_FFFF); rd("R2", 2'd3);
    check_word("R2", bus_rdata, 32'h0000_017F);
    step(1, 2'd3, 32'h0000_0018); rd("R2", 2'd3);
    step(1, 2'd0, 32'h0000_0055); rd("R2", 2'd0);

    // R10 stopped: values commit; start counts from 0. R3 R4 R5 normal waveform
    tag = "R10";
    step(1, 2'd1, 10); step(1, 2'd2, 3); idle(2);
    tag = "R3 R4 R5";
    step(1, 2'd3, 32'h10B);
    for (int i = 0; i < 25; i++) begin
      if (i == 7) step(1, 2'd0, 32'h0000_0002); else rd("R3", 2'd0);
    end
    rd("R2", 2'd0);

    // R7 mid-period update waits for wrap
    tag = "R7";
    idle(4);
    step(1, 2'd2, 7); step(1, 2'd1, 12); idle(30);

    // R5 inverted polarity, duty beyond period, short periods
    tag = "R5";
    step(1, 2'd3, 32'h113); idle(26);
    tag = "R4";
    step(1, 2'd2, 20); idle(30);
    tag = "R3";
    step(1, 2'd1, 1); idle(8); step(1, 2'd1, 0); step(1, 2'd2, 0); idle(8);

    // R6 enable with wrong mode, and stopped idle level
    tag = "R6";
    step(1, 2'd1, 9); step(1, 2'd2, 4);
    step(1, 2'd3, 32'h015); idle(6); rd("R6", 2'd0);
    step(1, 2'd3, 32'h01F); idle(6);
    step(1, 2'd3, 32'h000); idle(4);
    step(1, 2'd3, 32'h10B); idle(20);

    // R8 lock holds updates; R9 release applies all at next boundary
    tag = "R8";
    step(1, 2'd3, 32'h14B);
    step(1, 2'd1, 5); step(1, 2'd2, 1); step(1, 2'd3, 32'h153);
    idle(30); rd("R8", 2'd1);
    tag = "R9";
    step(1, 2'd3, 32'h113); idle(25);

    // random mix
    tag = "R3 R4 R7 R8 R9 random";
    for (int i = 0; i < 4000; i++) begin
      int op;
      op = int'($urandom_range(0, 19));
      if (op == 0) begin
        logic [DW-1:0] c;
        c = $urandom() & 32'h17F;
        if ($urandom_range(0, 9) < 8) c = (c & ~32'h7) | 32'h3;
        step(1, 2'd3, c);
      end else if (op == 1) step(1, 2'd1, $urandom_range(0, 24));
      else if (op == 2)     step(1, 2'd2, $urandom_range(0, 26));
      else if (op == 3)     step(1, 2'd0, $urandom());
      else if (op < 8)      rd("R2", 2'($urandom_range(0, 3)));
      else                  step(0, 2'd0, '0);
    end

    idle(2);
    finish_run();
  end

endmodule